// File: doc/BRIEF.md
# Single-Word AHB-Lite Master with Failure Capture

This block sits on the system side of a serial-to-bus bridge. The serial front end hands it one request at a time: an address, a direction and, for writes, a 32-bit word. The block runs that request as a single 32-bit AHB-Lite transfer, with one address phase and one data phase, and then returns a one-cycle response. The response carries the read word and a pass/fail bit.

Each data phase is watched in two ways. A slave ERROR response marks the transfer as failed. A slave that keeps HREADY low for too long is abandoned once a parameterised number of wait cycles has passed, and that case is reported as a separate failure kind. The first failure is held in a sticky record of flag, kind and faulting address until the system pulses a clear input. Later failures do not overwrite that record while it is held.

Top module: `ahb_word_master`

## Requirements
- R1: Every transfer is issued as one NONSEQ (HTRANS 2'b10) address phase with HSIZE 3'b010 (word) and HBURST 3'b000 (single). HTRANS returns to IDLE (2'b00) in the cycle after the address is accepted.
- R2: A request is accepted only while `req_ready_o` is high, which is only when no transfer is in progress. While HREADY is low during the address phase, HTRANS stays NONSEQ and HADDR and HWRITE stay unchanged.
- R3: During the data phase of a write, `hwdata_o` carries the request's write word and `hwrite_o` is 1.
- R4: The cycle after the data-phase edge where HREADY is high, `rsp_valid_o` is high for exactly one cycle. A successful read returns HRDATA in `rsp_rdata_o`. A write returns zero.
- R5: If HRESP is high when the data phase completes, the response has `rsp_err_o`=1 and `rsp_rdata_o`=0, and failure kind 2'b01 is recorded.
- R6: If HREADY is low for TIMEOUT_LIMIT consecutive data-phase cycles (default 255), the transfer is abandoned on the last of those cycles. The response is then an error with zero data, and failure kind 2'b10 is recorded. With TIMEOUT_LIMIT-1 wait cycles the transfer completes normally.
- R7: `err_flag_o` stays set until `err_clr_i` is pulsed. A clear with no new failure in the same cycle sets the flag to 0, `err_type_o` to 2'b00 and `err_addr_o` to 0 on the next cycle.
- R8: A failure that happens while the flag is already set leaves `err_type_o` and `err_addr_o` unchanged.
- R9: A failure that completes in the same cycle as a clear pulse is captured as a new record with its own kind and address.
- R10: After reset, HTRANS is IDLE, `req_ready_o`=1, `rsp_valid_o`=0, `err_flag_o`=0, `err_type_o`=2'b00 and `err_addr_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe from the serial side |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Byte address of the word |
| req_wdata_i | input | 32 | Write word |
| req_ready_o | output | 1 | Idle and able to take a request |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 32 | Read word, zero on failure or write |
| rsp_err_o | output | 1 | Transfer failed |
| err_clr_i | input | 1 | Clears the failure record |
| err_flag_o | output | 1 | Sticky failure indication |
| err_type_o | output | 2 | 00 none, 01 slave error, 10 timeout |
| err_addr_o | output | AW | Address of the first captured failure |
| haddr_o | output | AW | AHB address |
| htrans_o | output | 2 | AHB transfer type |
| hwrite_o | output | 1 | AHB direction |
| hsize_o | output | 3 | AHB size, always word |
| hburst_o | output | 3 | AHB burst, always single |
| hwdata_o | output | 32 | AHB write data |
| hrdata_i | input | 32 | AHB read data |
| hready_i | input | 1 | AHB ready |
| hresp_i | input | 1 | AHB error response |

## Verification
The hardest condition to reach from the ports is a failure that completes in the same cycle as a clear pulse while an earlier failure is still being held. The bench sets up that condition in stages. It first leaves a slave-error record in place. It then runs a second erroring read and drives `err_clr_i` in the exact cycle that the scripted slave raises HREADY with HRESP. A timeout that lands on an already-set flag is reached the same way, by holding HREADY low for the full limit after an uncleared failure. The limit boundary is covered by one transfer with one wait cycle fewer than the limit, which must succeed.

// File: rtl/ahb_wm_pkg.sv
package ahb_wm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} seq_state_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'b00,
    ERR_RESP = 2'b01,
    ERR_TMO  = 2'b10
  } err_kind_e;

  localparam logic [1:0] HTRANS_IDLE   = 2'b00;
  localparam logic [1:0] HTRANS_NONSEQ = 2'b10;
  localparam logic [2:0] HSIZE_WORD    = 3'b010;
  localparam logic [2:0] HBURST_SINGLE = 3'b000;

  typedef struct packed {
    logic      done;
    logic      fail;
    err_kind_e kind;
  } xfer_end_t;
endpackage

// File: rtl/ahb_wm_wait_cnt.sv
module ahb_wm_wait_cnt #(
  parameter int unsigned LIMIT = 255
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  // expire on the LIMIT-th low cycle
  assign expired_o = tick_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/ahb_wm_seq.sv
module ahb_wm_seq
  import ahb_wm_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          req_ready_o,
  input  logic          hready_i,
  input  logic          hresp_i,
  input  logic [DW-1:0] hrdata_i,
  input  logic          tmo_i,
  output logic [AW-1:0] haddr_o,
  output logic [1:0]    htrans_o,
  output logic          hwrite_o,
  output logic [DW-1:0] hwdata_o,
  output logic          start_o,
  output logic          tick_o,
  output logic          dphase_o,
  output xfer_end_t     end_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          rsp_err_o
);
  seq_state_e    state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          write_q;
  logic          done, resp_fail, tmo;

  assign dphase_o  = (state_q == ST_DATA);
  assign done      = dphase_o && hready_i;
  assign resp_fail = done && hresp_i;
  assign tick_o    = dphase_o && !hready_i;
  assign tmo       = tick_o && tmo_i;
  assign start_o   = (state_q == ST_ADDR) && hready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) state_d = ST_ADDR;
      ST_ADDR: if (hready_i)    state_d = ST_DATA;
      ST_DATA: if (done || tmo) state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        write_q <= req_write_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= done || tmo;
      rsp_err_o   <= resp_fail || tmo;
      rsp_rdata_o <= (done && !write_q && !hresp_i) ? hrdata_i : '0;
    end
  end

  always_comb begin
    end_o.done = done || tmo;
    end_o.fail = resp_fail || tmo;
    end_o.kind = tmo ? ERR_TMO : (resp_fail ? ERR_RESP : ERR_NONE);
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign htrans_o    = (state_q == ST_ADDR) ? HTRANS_NONSEQ : HTRANS_IDLE;
  assign haddr_o     = addr_q;
  assign hwrite_o    = write_q;
  assign hwdata_o    = wdata_q;
endmodule

// File: rtl/ahb_wm_err_cap.sv
module ahb_wm_err_cap
  import ahb_wm_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  xfer_end_t     end_i,
  input  logic [AW-1:0] addr_i,
  input  logic          clr_i,
  output logic          flag_o,
  output logic [1:0]    type_o,
  output logic [AW-1:0] addr_o
);
  logic capture;

  // first failure wins; a clear in the same cycle makes room for the new one
  assign capture = end_i.done && end_i.fail && (!flag_o || clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      type_o <= ERR_NONE;
      addr_o <= '0;
    end else if (capture) begin
      flag_o <= 1'b1;
      type_o <= end_i.kind;
      addr_o <= addr_i;
    end else if (clr_i) begin
      flag_o <= 1'b0;
      type_o <= ERR_NONE;
      addr_o <= '0;
    end
  end
endmodule

// File: rtl/ahb_word_master.sv
module ahb_word_master
  import ahb_wm_pkg::*;
#(
  parameter int unsigned AW            = 32,
  parameter int unsigned TIMEOUT_LIMIT = 255
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [31:0]   req_wdata_i,
  output logic          req_ready_o,
  output logic          rsp_valid_o,
  output logic [31:0]   rsp_rdata_o,
  output logic          rsp_err_o,
  input  logic          err_clr_i,
  output logic          err_flag_o,
  output logic [1:0]    err_type_o,
  output logic [AW-1:0] err_addr_o,
  output logic [AW-1:0] haddr_o,
  output logic [1:0]    htrans_o,
  output logic          hwrite_o,
  output logic [2:0]    hsize_o,
  output logic [2:0]    hburst_o,
  output logic [31:0]   hwdata_o,
  input  logic [31:0]   hrdata_i,
  input  logic          hready_i,
  input  logic          hresp_i
);
  localparam int unsigned DW = 32;

  logic      start, tick, tmo, dphase;
  xfer_end_t xend;

  ahb_wm_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_ready_o (req_ready_o),
    .hready_i    (hready_i),
    .hresp_i     (hresp_i),
    .hrdata_i    (hrdata_i),
    .tmo_i       (tmo),
    .haddr_o     (haddr_o),
    .htrans_o    (htrans_o),
    .hwrite_o    (hwrite_o),
    .hwdata_o    (hwdata_o),
    .start_o     (start),
    .tick_o      (tick),
    .dphase_o    (dphase),
    .end_o       (xend),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .rsp_err_o   (rsp_err_o)
  );

  ahb_wm_wait_cnt #(.LIMIT(TIMEOUT_LIMIT)) u_wait (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .tick_i    (tick),
    .expired_o (tmo)
  );

  ahb_wm_err_cap #(.AW(AW)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .end_i  (xend),
    .addr_i (haddr_o),
    .clr_i  (err_clr_i),
    .flag_o (err_flag_o),
    .type_o (err_type_o),
    .addr_o (err_addr_o)
  );

  assign hsize_o  = HSIZE_WORD;
  assign hburst_o = HBURST_SINGLE;
endmodule

// File: rtl/ahb_word_master_chk.sv
module ahb_word_master_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic [31:0]   rsp_rdata_o,
  input logic          rsp_err_o,
  input logic          err_clr_i,
  input logic          err_flag_o,
  input logic [1:0]    err_type_o,
  input logic [AW-1:0] err_addr_o,
  input logic [AW-1:0] haddr_o,
  input logic [1:0]    htrans_o,
  input logic          hwrite_o,
  input logic          hready_i,
  input logic          hresp_i,
  input logic          dphase
);
  a_r1_single_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o == 2'b10 && hready_i) |=> (htrans_o == 2'b00));

  a_r2_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o == 2'b10 && !hready_i) |=>
      (htrans_o == 2'b10 && $stable(haddr_o) && $stable(hwrite_o)));

  a_r2_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o == 2'b10) |-> !req_ready_o);

  a_r4_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r5_err_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> (rsp_rdata_o == 32'h0));

  a_r5_resp_reported: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dphase && hready_i && hresp_i) |=> (rsp_valid_o && rsp_err_o && err_flag_o));

  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_flag_o && !err_clr_i) |=> err_flag_o);

  a_r8_record_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_flag_o && !err_clr_i) |=> ($stable(err_addr_o) && $stable(err_type_o)));

  a_r7_type_matches_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_flag_o == (err_type_o != 2'b00));
endmodule

bind ahb_word_master ahb_word_master_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_rdata_o (rsp_rdata_o),
  .rsp_err_o   (rsp_err_o),
  .err_clr_i   (err_clr_i),
  .err_flag_o  (err_flag_o),
  .err_type_o  (err_type_o),
  .err_addr_o  (err_addr_o),
  .haddr_o     (haddr_o),
  .htrans_o    (htrans_o),
  .hwrite_o    (hwrite_o),
  .hready_i    (hready_i),
  .hresp_i     (hresp_i),
  .dphase      (dphase)
);

// File: tb/tb_ahb_word_master.sv
module tb_ahb_word_master;
  localparam int LIM = 255;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [31:0] req_addr_i = '0, req_wdata_i = '0;
  logic        req_ready_o, rsp_valid_o, rsp_err_o;
  logic [31:0] rsp_rdata_o;
  logic        err_clr_i = 1'b0;
  logic        err_flag_o;
  logic [1:0]  err_type_o;
  logic [31:0] err_addr_o, haddr_o, hwdata_o;
  logic [1:0]  htrans_o;
  logic        hwrite_o;
  logic [2:0]  hsize_o, hburst_o;
  logic [31:0] hrdata_i = '0;
  logic        hready_i = 1'b1, hresp_i = 1'b0;

  int tests = 0, fails = 0;
  bit done_flag = 0;

  // bench model of the failure record
  bit         m_flag = 0;
  logic [1:0] m_type = 2'b00;
  logic [31:0] m_addr = '0;

  always #5 clk_i = ~clk_i;

  ahb_word_master #(.AW(32), .TIMEOUT_LIMIT(LIM)) dut (.*);

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [8:0]  waits;
    logic        err;
    logic        clr;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b1, 32'h0000_1000, 32'hA5A5_0001, 32'h0,          9'd0,   1'b0, 1'b0},
    '{1'b0, 32'h0000_2004, 32'h0,          32'h1234_5678, 9'd0,   1'b0, 1'b0},
    '{1'b0, 32'h0000_2008, 32'h0,          32'hDEAD_BEEF, 9'd3,   1'b0, 1'b0},
    '{1'b1, 32'h0000_3000, 32'h5A5A_7777, 32'h0,          9'd2,   1'b0, 1'b0},
    '{1'b0, 32'h0000_4000, 32'h0,          32'hCAFE_0000, 9'd1,   1'b1, 1'b0},
    '{1'b1, 32'h0000_5000, 32'h1111_0000, 32'h0,          9'd255, 1'b0, 1'b1},
    '{1'b0, 32'h0000_6000, 32'h0,          32'h0BAD_F00D, 9'd254, 1'b0, 1'b0},
    '{1'b0, 32'h0000_7000, 32'h0,          32'h7777_0000, 9'd255, 1'b0, 1'b1},
    '{1'b1, 32'h0000_8000, 32'h8888_0000, 32'h0,          9'd1,   1'b1, 1'b0},
    '{1'b0, 32'h0000_9000, 32'h0,          32'h1111_2222, 9'd0,   1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic chk_record(input string tag);
    chk(err_flag_o == m_flag, {tag, " flag"}, 32'(err_flag_o), 32'(m_flag));
    chk(err_type_o == m_type, {tag, " type"}, 32'(err_type_o), 32'(m_type));
    chk(err_addr_o == m_addr, {tag, " addr"}, err_addr_o, m_addr);
  endtask

  // called at a negedge with the block idle
  task automatic do_xfer(input logic wr, input logic [31:0] addr, input logic [31:0] wdata,
                         input logic [31:0] rdata, input int waits, input logic err,
                         input int addr_waits, input logic clr_at_end);
    bit tmo_exp = (waits >= LIM);
    int nw = tmo_exp ? LIM : waits;
    bit fail_exp = tmo_exp || err;
    logic [31:0] exp_rd = (!wr && !fail_exp) ? rdata : 32'h0;
    chk(req_ready_o == 1'b1, "R2 ready when idle", 32'(req_ready_o), 32'd1);
    req_valid_i = 1'b1; req_write_i = wr; req_addr_i = addr; req_wdata_i = wdata;
    @(negedge clk_i);
    req_valid_i = 1'b0; req_addr_i = 32'hFFFF_FFFF;
    chk(htrans_o == 2'b10, "R1 NONSEQ issued", 32'(htrans_o), 32'h2);
    chk(hsize_o == 3'b010 && hburst_o == 3'b000, "R1 size/burst",
        {26'd0, hsize_o, hburst_o}, {26'd0, 3'b010, 3'b000});
    chk(req_ready_o == 1'b0, "R2 busy not ready", 32'(req_ready_o), 32'd0);
    for (int k = 0; k < addr_waits; k++) begin
      hready_i = 1'b0;
      @(negedge clk_i);
      chk(htrans_o == 2'b10 && haddr_o == addr && hwrite_o == wr, "R2 address held",
          haddr_o, addr);
    end
    hready_i = 1'b1;
    chk(haddr_o == addr && hwrite_o == wr, "R2 address", haddr_o, addr);
    @(negedge clk_i);
    chk(htrans_o == 2'b00, "R1 idle in data phase", 32'(htrans_o), 32'h0);
    if (wr) chk(hwdata_o == wdata && hwrite_o, "R3 write data", hwdata_o, wdata);
    for (int k = 0; k < nw; k++) begin
      hready_i = 1'b0;
      hresp_i  = err && !tmo_exp && (k == waits - 1);
      hrdata_i = 32'hFFFF_FFFF;
      @(negedge clk_i);
      if (k + 1 < nw)
        chk(rsp_valid_o == 1'b0, "R6 still waiting", 32'(rsp_valid_o), 32'd0);
    end
    if (!tmo_exp) begin
      hready_i = 1'b1; hresp_i = err; hrdata_i = rdata; err_clr_i = clr_at_end;
      @(negedge clk_i);
      err_clr_i = 1'b0;
    end
    hready_i = 1'b1; hresp_i = 1'b0; hrdata_i = 32'h0;
    chk(rsp_valid_o == 1'b1, "R4 response valid", 32'(rsp_valid_o), 32'd1);
    chk(rsp_err_o == fail_exp, tmo_exp ? "R6 timeout error" : "R5 error bit",
        32'(rsp_err_o), 32'(fail_exp));
    chk(rsp_rdata_o == exp_rd, fail_exp ? "R5 zero data" : "R4 read data", rsp_rdata_o, exp_rd);
    if (fail_exp && (!m_flag || clr_at_end)) begin
      m_flag = 1; m_type = tmo_exp ? 2'b10 : 2'b01; m_addr = addr;
    end else if (clr_at_end) begin
      m_flag = 0; m_type = 2'b00; m_addr = '0;
    end
    chk_record("R8 record after transfer");
    @(negedge clk_i);
    chk(rsp_valid_o == 1'b0, "R4 single pulse", 32'(rsp_valid_o), 32'd0);
  endtask

  task automatic pulse_clear();
    err_clr_i = 1'b1;
    @(negedge clk_i);
    err_clr_i = 1'b0;
    m_flag = 0; m_type = 2'b00; m_addr = '0;
    chk_record("R7 cleared");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(htrans_o == 2'b00, "R10 htrans idle", 32'(htrans_o), 32'h0);
    chk(req_ready_o == 1'b1, "R10 ready", 32'(req_ready_o), 32'd1);
    chk(rsp_valid_o == 1'b0, "R10 no response", 32'(rsp_valid_o), 32'd0);
    chk_record("R10 record");
    rst_ni = 1'b1;
    @(negedge clk_i);

    foreach (VECS[i]) begin
      do_xfer(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].rdata,
              int'(VECS[i].waits), VECS[i].err, 0, 1'b0);
      if (VECS[i].clr) pulse_clear();
    end

    // R2: slave still busy during the address phase
    do_xfer(1'b0, 32'h0000_A000, 32'h0, 32'h4242_4242, 1, 1'b0, 3, 1'b0);

    // R7: clear with no record is harmless; sticky across idle cycles
    pulse_clear();
    do_xfer(1'b1, 32'h0000_B000, 32'h1, 32'h0, 2, 1'b1, 0, 1'b0);
    repeat (5) @(negedge clk_i);
    chk_record("R7 sticky while idle");

    // R9: new failure on the clear cycle replaces the record
    do_xfer(1'b0, 32'h0000_C000, 32'h0, 32'h9, 1, 1'b1, 0, 1'b1);
    chk(err_addr_o == 32'h0000_C000, "R9 new address", err_addr_o, 32'h0000_C000);
    // R8: a later failure leaves the record alone
    do_xfer(1'b0, 32'h0000_D000, 32'h0, 32'h9, 2, 1'b1, 0, 1'b0);
    chk(err_addr_o == 32'h0000_C000, "R8 first address kept", err_addr_o, 32'h0000_C000);
    pulse_clear();

    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule